// File: doc/BRIEF.md
# Calendar Clock Register Sequencer

This block drives a serial clock chip through a lower engine that moves one byte per transaction. It does no wire-level timing of its own. A host gives one of three commands: load a new calendar time, read the current time, or check that the chip is present.

- **Load:** the block converts the seven binary time fields to BCD. It writes them to the clock registers only while the chip's write protect is open and its oscillator is halted. The halt and the restart are each a read-modify-write of the seconds register.
- **Read:** the block fetches all seven registers and decodes them to binary. It returns the month zero-based and the year as years since 1900, with two-digit years below 70 taken as the 2000s. The fields change as one snapshot.
- **Presence check:** the block writes a fixed pattern to the first scratch RAM byte and reads it back.

Each transaction goes through a request/acknowledge port. If the engine stays silent for too long, the command is aborted and flagged.

Top module: `rtc_time_seq`

## Requirements
- R1: A load command issues exactly 13 transactions in this order (W = write, R = read, address in hex): W 07 data 00, R 00, W 00, W 00, W 01, W 02, W 05, W 03, W 04, W 06, R 00, W 00, W 07 data 80. The register addresses are seconds 00, minutes 01, hours 02, day of month 03, month 04, weekday 05, year 06, control 07.
- R2: The written field bytes are BCD, with the tens digit in bits 7:4 and the units in bits 3:0. Month is stored as the zero-based input plus 1, and year as the input modulo 100.
- R3: The write that follows the first seconds read carries the byte read with bit 7 set (halt). The write that follows the second seconds read carries the byte read with bit 7 cleared (run).
- R4: A read command issues 7 reads at addresses 00, 01, 02, 05, 03, 04, 06. Each field is returned in binary. The month is decoded minus 1, and a decoded year below 70 gets 100 added.
- R5: Bit 7 of the seconds byte is ignored when decoding seconds.
- R6: `rd_valid` goes low when a read command is accepted and high only when all seven fields have been captured. The `rd_*` outputs keep their previous values until that moment and then all change in the same cycle.
- R7: A presence check writes 42 to address 20 and then reads address 20. `probe_fail` is 1 if the byte read differs from 42, and 0 otherwise.
- R8: `txn_req` stays high with `txn_write`, `txn_addr` and `txn_wdata` stable until `txn_ack`. Each request completes exactly one transaction, and `txn_req` is low for at least one cycle between transactions.
- R9: If `txn_ack` has not come after `TIMEOUT_CYC` cycles of `txn_req` high, the block drops `txn_req`, aborts the command and sets `timeout_err`. A read aborted this way leaves `rd_valid` low, and a presence check aborted this way reports `probe_fail`. `timeout_err` clears when the next command is accepted.
- R10: When commands arrive in the same cycle, load wins over read, and read wins over presence check. Commands that arrive while `busy` is high are ignored.
- R11: After reset, `busy`, `done`, `txn_req`, `rd_valid`, `timeout_err` and `probe_fail` are all 0.
- R12: `done` pulses high for exactly one cycle at the end of each accepted command. Every result of that command is visible in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_set | input | 1 | Start a load of the set_* fields |
| cmd_read | input | 1 | Start a time read |
| cmd_probe | input | 1 | Start a presence check |
| set_sec | input | 8 | Seconds, binary |
| set_min | input | 8 | Minutes, binary |
| set_hour | input | 8 | Hours, binary |
| set_wday | input | 8 | Weekday, binary |
| set_mday | input | 8 | Day of month, binary |
| set_mon | input | 8 | Month, zero-based binary |
| set_year | input | 8 | Years since 1900 |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle end-of-command pulse |
| timeout_err | output | 1 | Last command aborted on timeout |
| probe_fail | output | 1 | Last presence check failed |
| rd_valid | output | 1 | rd_* hold a complete snapshot |
| rd_sec | output | 8 | Seconds read |
| rd_min | output | 8 | Minutes read |
| rd_hour | output | 8 | Hours read |
| rd_wday | output | 8 | Weekday read |
| rd_mday | output | 8 | Day of month read |
| rd_mon | output | 8 | Month read, zero-based |
| rd_year | output | 8 | Years since 1900 read |
| txn_req | output | 1 | Transaction request to engine |
| txn_write | output | 1 | 1 = write, 0 = read |
| txn_addr | output | 6 | Register address |
| txn_wdata | output | 8 | Write byte |
| txn_ack | input | 1 | Engine completion, one cycle |
| txn_rdata | input | 8 | Read byte, valid with txn_ack |

## Verification
The bench targets several corner cases:

- **Year around the century rule:** loads of 100, 169, 70 and 199 show whether modulo-100 storage and the below-70 rule are both right. A design that skips either returns a year a century off.
- **Halted seconds byte:** a seconds register with bit 7 set must decode to plain seconds. Without the mask, 80 would be added to the result.
- **Seconds read-modify-write:** the bench compares the halt and run writes against the byte it supplied. A sequencer that writes a constant there, or the wrong polarity, leaves the oscillator in the wrong state.
- **Silent engine:** the bench checks the exact request length, the abort, and that no half-filled snapshot is marked valid.
- **Command collisions:** a design that lets a command in while busy shows extra transactions in the log.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NFIELD = 7;
  localparam int STEP_W = 4;

  // register map of the clock chip
  localparam logic [ADDR_W-1:0] A_SEC  = 6'h00;
  localparam logic [ADDR_W-1:0] A_MIN  = 6'h01;
  localparam logic [ADDR_W-1:0] A_HOUR = 6'h02;
  localparam logic [ADDR_W-1:0] A_MDAY = 6'h03;
  localparam logic [ADDR_W-1:0] A_MON  = 6'h04;
  localparam logic [ADDR_W-1:0] A_WDAY = 6'h05;
  localparam logic [ADDR_W-1:0] A_YEAR = 6'h06;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h07;
  localparam logic [ADDR_W-1:0] A_RAM0 = 6'h20;

  localparam logic [DATA_W-1:0] WP_OPEN   = 8'h00;
  localparam logic [DATA_W-1:0] WP_CLOSE  = 8'h80;
  localparam logic [DATA_W-1:0] HALT_BIT  = 8'h80;
  localparam logic [DATA_W-1:0] PROBE_PAT = 8'h42;

  // field slots, in load order: sec, min, hour, wday, mday, mon, year
  localparam int F_SEC  = 0;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef enum logic [1:0] {M_SET, M_READ, M_PROBE} mode_e;
  typedef enum logic [1:0] {D_CONST, D_FIELD, D_HALT, D_RUN} dsel_e;
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_END} state_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    dsel_e             dsel;
    logic [DATA_W-1:0] konst;
    logic [2:0]        fidx;
  } op_t;

  function automatic logic [ADDR_W-1:0] field_addr(input logic [2:0] f);
    case (f)
      3'd0:    return A_SEC;
      3'd1:    return A_MIN;
      3'd2:    return A_HOUR;
      3'd3:    return A_WDAY;
      3'd4:    return A_MDAY;
      3'd5:    return A_MON;
      default: return A_YEAR;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] last_step(input mode_e m);
    case (m)
      M_SET:   return 4'd12;
      M_READ:  return 4'd6;
      default: return 4'd1;
    endcase
  endfunction

  function automatic op_t step_op(input mode_e m, input logic [STEP_W-1:0] i);
    op_t o;
    o.wr    = 1'b1;
    o.addr  = A_SEC;
    o.dsel  = D_CONST;
    o.konst = '0;
    o.fidx  = '0;
    case (m)
      M_SET: begin
        if (i == 4'd0) begin
          o.addr  = A_CTRL;
          o.konst = WP_OPEN;
        end else if (i == 4'd1 || i == 4'd10) begin
          o.wr = 1'b0;
        end else if (i == 4'd2) begin
          o.dsel = D_HALT;
        end else if (i == 4'd11) begin
          o.dsel = D_RUN;
        end else if (i == 4'd12) begin
          o.addr  = A_CTRL;
          o.konst = WP_CLOSE;
        end else begin
          o.fidx = 3'(i - 4'd3);
          o.addr = field_addr(o.fidx);
          o.dsel = D_FIELD;
        end
      end
      M_READ: begin
        o.wr   = 1'b0;
        o.fidx = i[2:0];
        o.addr = field_addr(i[2:0]);
      end
      default: begin
        o.addr  = A_RAM0;
        o.konst = PROBE_PAT;
        o.wr    = (i == 4'd0);
      end
    endcase
    return o;
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = (v / 8'd10) % 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction

endpackage

// File: rtl/rtc_seq_txn_port.sv
module rtc_seq_txn_port
  import rtc_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024,
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              launch,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              txn_ack,
  output logic              txn_req,
  output logic              txn_write,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [DATA_W-1:0] txn_wdata,
  output logic              fin,
  output logic              tmo
);

  logic              req_q, req_n;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              cnt_en;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  assign fin = req_q & txn_ack;
  assign tmo = req_q & ~txn_ack & (cnt_q == CNT_LAST);

  always_comb begin
    req_n  = req_q;
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (launch) begin
      req_n  = 1'b1;
      cnt_n  = '0;
      cnt_en = 1'b1;
    end else if (fin || tmo) begin
      req_n = 1'b0;
    end else if (req_q) begin
      cnt_n  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      req_q <= req_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (launch) begin
        wr_q    <= op_wr;
        addr_q  <= op_addr;
        wdata_q <= op_wdata;
      end
    end
  end

  assign txn_req   = req_q;
  assign txn_write = wr_q;
  assign txn_addr  = addr_q;
  assign txn_wdata = wdata_q;

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_q && !txn_ack && !tmo) |=> (req_q && $stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));

  a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_q && txn_ack) |=> !req_q);

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    req_q |-> (cnt_q <= CNT_LAST));

  a_r8_launch_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    launch |-> !req_q);

endmodule

// File: rtl/rtc_seq_ctrl.sv
module rtc_seq_ctrl
  import rtc_seq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          cmd_set,
  input  logic                          cmd_read,
  input  logic                          cmd_probe,
  input  logic [NFIELD-1:0][DATA_W-1:0] set_fld,
  input  logic                          fin,
  input  logic                          tmo,
  input  logic [DATA_W-1:0]             rdata,
  output logic                          launch,
  output logic                          op_wr,
  output logic [ADDR_W-1:0]             op_addr,
  output logic [DATA_W-1:0]             op_wdata,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic                          pfail,
  output logic                          snap_clr,
  output logic                          cap_en,
  output logic [2:0]                    cap_idx,
  output logic                          commit
);

  state_e                        st_q, st_n;
  mode_e                         mode_q, mode_n;
  logic [STEP_W-1:0]             step_q, step_n;
  logic [DATA_W-1:0]             held_q, held_n;
  logic                          err_q, err_n;
  logic                          pfail_q, pfail_n;
  logic                          done_q;
  logic [NFIELD-1:0][DATA_W-1:0] fld_q;
  logic [NFIELD-1:0][DATA_W-1:0] enc;
  logic                          fld_en;
  op_t                           cur_op;

  // encode the host fields into register bytes at accept time
  for (genvar g = 0; g < NFIELD; g++) begin : g_enc
    if (g == F_MON) begin : g_mon
      assign enc[g] = bin2bcd(set_fld[g] + 8'd1);
    end else if (g == F_YEAR) begin : g_year
      assign enc[g] = bin2bcd(set_fld[g] % 8'd100);
    end else begin : g_plain
      assign enc[g] = bin2bcd(set_fld[g]);
    end
  end

  assign cur_op = step_op(mode_q, step_q);

  always_comb begin
    st_n     = st_q;
    mode_n   = mode_q;
    step_n   = step_q;
    held_n   = held_q;
    err_n    = err_q;
    pfail_n  = pfail_q;
    fld_en   = 1'b0;
    snap_clr = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (cmd_set || cmd_read || cmd_probe) begin
          st_n   = S_LAUNCH;
          step_n = '0;
          err_n  = 1'b0;
          if (cmd_set) begin
            mode_n = M_SET;
            fld_en = 1'b1;
          end else if (cmd_read) begin
            mode_n   = M_READ;
            snap_clr = 1'b1;
          end else begin
            mode_n  = M_PROBE;
            pfail_n = 1'b0;
          end
        end
      end
      S_LAUNCH: st_n = S_WAIT;
      S_WAIT: begin
        if (fin) begin
          if (!cur_op.wr) held_n = rdata;
          if (mode_q == M_PROBE && !cur_op.wr && rdata != PROBE_PAT) pfail_n = 1'b1;
          if (step_q == last_step(mode_q)) begin
            st_n = S_END;
          end else begin
            step_n = step_q + 1'b1;
            st_n   = S_LAUNCH;
          end
        end else if (tmo) begin
          err_n = 1'b1;
          if (mode_q == M_PROBE) pfail_n = 1'b1;
          st_n = S_END;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      mode_q  <= M_SET;
      step_q  <= '0;
      held_q  <= '0;
      err_q   <= 1'b0;
      pfail_q <= 1'b0;
      done_q  <= 1'b0;
      fld_q   <= '0;
    end else begin
      st_q    <= st_n;
      mode_q  <= mode_n;
      step_q  <= step_n;
      held_q  <= held_n;
      err_q   <= err_n;
      pfail_q <= pfail_n;
      done_q  <= (st_q == S_END);
      if (fld_en) fld_q <= enc;
    end
  end

  always_comb begin
    case (cur_op.dsel)
      D_FIELD: op_wdata = fld_q[cur_op.fidx];
      D_HALT:  op_wdata = held_q | HALT_BIT;
      D_RUN:   op_wdata = held_q & ~HALT_BIT;
      default: op_wdata = cur_op.konst;
    endcase
  end

  assign launch  = (st_q == S_LAUNCH);
  assign op_wr   = cur_op.wr;
  assign op_addr = cur_op.addr;
  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign pfail   = pfail_q;
  assign cap_en  = fin && (mode_q == M_READ) && (st_q == S_WAIT);
  assign cap_idx = step_q[2:0];
  assign commit  = (st_q == S_END) && (mode_q == M_READ) && !err_q;

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r1_step_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q != S_IDLE) |-> (step_q <= last_step(mode_q)));

  a_r9_tmo_aborts: assert property (@(posedge clk) disable iff (!rst_ni)
    (tmo && st_q == S_WAIT) |=> (st_q == S_END && err_q));

  a_r10_busy_holds_mode: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_WAIT) |=> $stable(mode_q));

endmodule

// File: rtl/rtc_seq_snapshot.sv
module rtc_seq_snapshot
  import rtc_seq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          clr,
  input  logic                          cap_en,
  input  logic [2:0]                    cap_idx,
  input  logic [DATA_W-1:0]             cap_data,
  input  logic                          commit,
  output logic [NFIELD-1:0][DATA_W-1:0] fld_out,
  output logic                          valid
);

  logic [NFIELD-1:0][DATA_W-1:0] stage_q;
  logic [NFIELD-1:0][DATA_W-1:0] dec;
  logic [NFIELD-1:0][DATA_W-1:0] out_q;
  logic                          valid_q, valid_n;

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    logic st_en;
    assign st_en = cap_en && (cap_idx == 3'(g));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    stage_q[g] <= '0;
      else if (st_en) stage_q[g] <= cap_data;
    end

    if (g == F_SEC) begin : g_sec
      assign dec[g] = bcd2bin(stage_q[g] & ~HALT_BIT);
    end else if (g == F_MON) begin : g_mon
      assign dec[g] = bcd2bin(stage_q[g]) - 8'd1;
    end else if (g == F_YEAR) begin : g_year
      logic [DATA_W-1:0] yr;
      assign yr     = bcd2bin(stage_q[g]);
      assign dec[g] = (yr < 8'd70) ? yr + 8'd100 : yr;
    end else begin : g_plain
      assign dec[g] = bcd2bin(stage_q[g]);
    end
  end

  always_comb begin
    valid_n = valid_q;
    if (clr)         valid_n = 1'b0;
    else if (commit) valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      if (commit) out_q <= dec;
    end
  end

  assign fld_out = out_q;
  assign valid   = valid_q;

  a_r6_no_commit_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    !(clr && commit));

endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq
  import rtc_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_set,
  input  logic       cmd_read,
  input  logic       cmd_probe,
  input  logic [7:0] set_sec,
  input  logic [7:0] set_min,
  input  logic [7:0] set_hour,
  input  logic [7:0] set_wday,
  input  logic [7:0] set_mday,
  input  logic [7:0] set_mon,
  input  logic [7:0] set_year,
  output logic       busy,
  output logic       done,
  output logic       timeout_err,
  output logic       probe_fail,
  output logic       rd_valid,
  output logic [7:0] rd_sec,
  output logic [7:0] rd_min,
  output logic [7:0] rd_hour,
  output logic [7:0] rd_wday,
  output logic [7:0] rd_mday,
  output logic [7:0] rd_mon,
  output logic [7:0] rd_year,
  output logic       txn_req,
  output logic       txn_write,
  output logic [5:0] txn_addr,
  output logic [7:0] txn_wdata,
  input  logic       txn_ack,
  input  logic [7:0] txn_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NFIELD-1:0][DATA_W-1:0] set_fld;
  logic [NFIELD-1:0][DATA_W-1:0] rd_fld;
  logic              launch, op_wr, fin, tmo;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic              snap_clr, cap_en, commit;
  logic [2:0]        cap_idx;

  assign set_fld = {set_year, set_mon, set_mday, set_wday, set_hour, set_min, set_sec};

  rtc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .cmd_set  (cmd_set),
    .cmd_read (cmd_read),
    .cmd_probe(cmd_probe),
    .set_fld  (set_fld),
    .fin      (fin),
    .tmo      (tmo),
    .rdata    (txn_rdata),
    .launch   (launch),
    .op_wr    (op_wr),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .busy     (busy),
    .done     (done),
    .err      (timeout_err),
    .pfail    (probe_fail),
    .snap_clr (snap_clr),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .commit   (commit)
  );

  rtc_seq_txn_port #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_port (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .launch   (launch),
    .op_wr    (op_wr),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .txn_ack  (txn_ack),
    .txn_req  (txn_req),
    .txn_write(txn_write),
    .txn_addr (txn_addr),
    .txn_wdata(txn_wdata),
    .fin      (fin),
    .tmo      (tmo)
  );

  rtc_seq_snapshot u_snap (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .clr     (snap_clr),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .cap_data(txn_rdata),
    .commit  (commit),
    .fld_out (rd_fld),
    .valid   (rd_valid)
  );

  assign rd_sec  = rd_fld[0];
  assign rd_min  = rd_fld[1];
  assign rd_hour = rd_fld[2];
  assign rd_wday = rd_fld[3];
  assign rd_mday = rd_fld[4];
  assign rd_mon  = rd_fld[5];
  assign rd_year = rd_fld[6];

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !txn_req);

  a_r6_valid_with_done: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rd_valid) |-> done);

  a_r9_err_then_done: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(timeout_err) |=> done);

  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);

endmodule

// File: tb/rtc_time_seq_bench.sv
`timescale 1ns/1ps
module rtc_time_seq_bench;

  localparam int TMO = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       cmd_set, cmd_read, cmd_probe;
  logic [7:0] set_sec, set_min, set_hour, set_wday, set_mday, set_mon, set_year;
  logic       busy, done, timeout_err, probe_fail, rd_valid;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_wday, rd_mday, rd_mon, rd_year;
  logic       txn_req, txn_write, txn_ack;
  logic [5:0] txn_addr;
  logic [7:0] txn_wdata, txn_rdata;

  rtc_time_seq #(.TIMEOUT_CYC(TMO)) u_rtc_time_seq (.*);

  // ---------------- engine model ----------------
  logic [7:0] mem [64];
  logic       log_wr   [64];
  logic [5:0] log_addr [64];
  logic [7:0] log_data [64];
  int         log_n;
  int         wcnt;
  int         ack_dly;
  logic       no_ack, bad_ram, log_clr, poke_en;
  logic [5:0] poke_addr;
  logic [7:0] poke_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
      txn_ack   <= 1'b0;
      txn_rdata <= 8'h00;
      log_n     <= 0;
      wcnt      <= 0;
    end else begin
      txn_ack <= 1'b0;
      if (poke_en) mem[poke_addr] <= poke_data;
      if (log_clr) log_n <= 0;
      if (txn_req && !txn_ack && !no_ack) begin
        if (wcnt >= ack_dly) begin
          wcnt    <= 0;
          txn_ack <= 1'b1;
          log_wr[log_n]   <= txn_write;
          log_addr[log_n] <= txn_addr;
          if (txn_write) begin
            mem[txn_addr]   <= txn_wdata;
            log_data[log_n] <= txn_wdata;
          end else begin
            txn_rdata       <= (bad_ram && txn_addr == 6'h20) ? mem[txn_addr] ^ 8'h01 : mem[txn_addr];
            log_data[log_n] <= (bad_ram && txn_addr == 6'h20) ? mem[txn_addr] ^ 8'h01 : mem[txn_addr];
          end
          log_n <= log_n + 1;
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  // ---------------- protocol monitor (R8) ----------------
  int   viol = 0;
  int   run_len = 0;
  int   max_run = 0;
  logic prev_hs = 1'b0, prev_req = 1'b0;
  logic [5:0] prev_addr = '0;
  logic [7:0] prev_wd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hs && txn_req) viol = viol + 1;
      if (prev_req && !prev_hs && txn_req && (txn_addr != prev_addr || txn_wdata != prev_wd)) viol = viol + 1;
      if (txn_req) run_len = run_len + 1; else run_len = 0;
      if (run_len > max_run) max_run = run_len;
    end
    prev_hs   = txn_req && txn_ack;
    prev_req  = txn_req;
    prev_addr = txn_addr;
    prev_wd   = txn_wdata;
  end

  // ---------------- checking ----------------
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) % 10) * 16 + (v % 10));
  endfunction

  task automatic poke(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic run_cmd(input logic s, input logic r, input logic p);
    @(negedge clk); cmd_set = s; cmd_read = r; cmd_probe = p;
    @(negedge clk); cmd_set = 1'b0; cmd_read = 1'b0; cmd_probe = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // sec, min, hour, wday, mday, mon(0-based), year-since-1900
  localparam logic [55:0] VEC [4] = '{
    {8'd0,  8'd0,  8'd0,  8'd1, 8'd1,  8'd0,  8'd100},
    {8'd59, 8'd59, 8'd23, 8'd7, 8'd31, 8'd11, 8'd169},
    {8'd45, 8'd30, 8'd12, 8'd3, 8'd15, 8'd5,  8'd70},
    {8'd9,  8'd8,  8'd7,  8'd6, 8'd28, 8'd1,  8'd199}
  };

  task automatic apply(input logic [55:0] v);
    {set_sec, set_min, set_hour, set_wday, set_mday, set_mon, set_year} = v;
  endtask

  task automatic check_set_log(input logic [55:0] v, input logic [7:0] prev);
    logic [14:0] exp [13];
    int f [7];
    logic [5:0] fa [7];
    fa = '{6'h00, 6'h01, 6'h02, 6'h05, 6'h03, 6'h04, 6'h06};
    for (int k = 0; k < 7; k++) f[k] = int'(v[55-8*k -: 8]);
    exp[0]  = {1'b1, 6'h07, 8'h00};
    exp[1]  = {1'b0, 6'h00, prev};
    exp[2]  = {1'b1, 6'h00, prev | 8'h80};
    for (int k = 0; k < 7; k++) begin
      int val;
      val = f[k];
      if (k == 5) val = f[k] + 1;
      if (k == 6) val = f[k] % 100;
      exp[3+k] = {1'b1, fa[k], bcd(val)};
    end
    exp[10] = {1'b0, 6'h00, bcd(f[0])};
    exp[11] = {1'b1, 6'h00, bcd(f[0]) & 8'h7F};
    exp[12] = {1'b1, 6'h07, 8'h80};
    chk("R1 set txn count", 32'(log_n), 32'd13);
    for (int k = 0; k < 13; k++) begin
      if (k == 2 || k == 11) chk("R3 halt/run rmw", {17'b0, log_wr[k], log_addr[k], log_data[k]}, {17'b0, exp[k]});
      else if (k >= 3 && k <= 9) chk("R2 bcd field write", {17'b0, log_wr[k], log_addr[k], log_data[k]}, {17'b0, exp[k]});
      else chk("R1 set txn", {17'b0, log_wr[k], log_addr[k], log_data[k]}, {17'b0, exp[k]});
    end
  endtask

  task automatic check_read(input logic [55:0] v);
    int y;
    logic [5:0] fa [7];
    fa = '{6'h00, 6'h01, 6'h02, 6'h05, 6'h03, 6'h04, 6'h06};
    y = int'(v[7:0]) % 100;
    if (y < 70) y = y + 100;
    chk("R4 read txn count", 32'(log_n), 32'd7);
    for (int k = 0; k < 7; k++) chk("R4 read addr", {25'b0, log_wr[k], log_addr[k]}, {25'b0, 1'b0, fa[k]});
    chk("R4 sec",  32'(rd_sec),  32'(v[55:48]));
    chk("R4 min",  32'(rd_min),  32'(v[47:40]));
    chk("R4 hour", 32'(rd_hour), 32'(v[39:32]));
    chk("R4 wday", 32'(rd_wday), 32'(v[31:24]));
    chk("R4 mday", 32'(rd_mday), 32'(v[23:16]));
    chk("R4 mon",  32'(rd_mon),  32'(v[15:8]));
    chk("R4 year", 32'(rd_year), 32'(y));
    chk("R6 valid at done", 32'(rd_valid), 32'd1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_set = 0; cmd_read = 0; cmd_probe = 0;
    no_ack = 0; bad_ram = 0; log_clr = 0; poke_en = 0; poke_addr = 0; poke_data = 0;
    ack_dly = 0;
    apply(VEC[0]);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy",  32'(busy), 0);
    chk("R11 done",  32'(done), 0);
    chk("R11 req",   32'(txn_req), 0);
    chk("R11 valid", 32'(rd_valid), 0);
    chk("R11 err",   32'(timeout_err), 0);
    chk("R11 pfail", 32'(probe_fail), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    poke(6'h00, 8'h25);

    // vector table: load then read back
    for (int i = 0; i < 4; i++) begin
      logic [7:0] prev;
      ack_dly = i % 3;
      apply(VEC[i]);
      prev = mem[0];
      clear_log();
      run_cmd(1, 0, 0);
      chk("R12 done at set end", 32'(done), 1);
      @(negedge clk);
      chk("R12 done single cycle", 32'(done), 0);
      check_set_log(VEC[i], prev);
      clear_log();
      run_cmd(0, 1, 0);
      check_read(VEC[i]);
    end

    // R5: halted seconds byte decodes without bit 7
    poke(6'h00, 8'hB7);
    run_cmd(0, 1, 0);
    chk("R5 seconds mask", 32'(rd_sec), 32'd37);

    // R6: snapshot held during a read in progress
    ack_dly = 3;
    poke(6'h00, 8'h11);
    @(negedge clk); cmd_read = 1'b1;
    @(negedge clk); cmd_read = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 valid low mid-read", 32'(rd_valid), 0);
    chk("R6 sec held mid-read", 32'(rd_sec), 32'd37);
    while (!done) @(negedge clk);
    chk("R6 sec updated", 32'(rd_sec), 32'd11);
    chk("R6 valid high", 32'(rd_valid), 1);
    ack_dly = 0;

    // R10 priority
    clear_log();
    run_cmd(1, 1, 1);
    chk("R10 set wins count", 32'(log_n), 32'd13);
    chk("R10 set wins first", {26'b0, log_wr[0], log_addr[0]}, {26'b0, 1'b1, 6'h07});
    clear_log();
    run_cmd(0, 1, 1);
    chk("R10 read beats probe count", 32'(log_n), 32'd7);
    chk("R10 read beats probe first", {26'b0, log_wr[0], log_addr[0]}, 32'd0);

    // R10 ignore while busy
    clear_log();
    @(negedge clk); cmd_set = 1'b1;
    @(negedge clk); cmd_set = 1'b0;
    repeat (5) @(negedge clk);
    cmd_read = 1'b1; cmd_probe = 1'b1;
    @(negedge clk); cmd_read = 1'b0; cmd_probe = 1'b0;
    while (!done) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R10 busy ignore count", 32'(log_n), 32'd13);
    chk("R10 busy ignore idle", 32'(busy), 0);

    // R7 presence check
    clear_log();
    run_cmd(0, 0, 1);
    chk("R7 probe pass", 32'(probe_fail), 0);
    chk("R7 probe write", {17'b0, log_wr[0], log_addr[0], log_data[0]}, {17'b0, 1'b1, 6'h20, 8'h42});
    chk("R7 probe read", {25'b0, log_wr[1], log_addr[1]}, {25'b0, 1'b0, 6'h20});
    bad_ram = 1'b1;
    run_cmd(0, 0, 1);
    chk("R7 probe mismatch", 32'(probe_fail), 1);
    bad_ram = 1'b0;
    run_cmd(0, 0, 1);
    chk("R7 probe recovers", 32'(probe_fail), 0);

    // R9 timeout on a read
    no_ack = 1'b1;
    max_run = 0;
    run_cmd(0, 1, 0);
    chk("R9 timeout err", 32'(timeout_err), 1);
    chk("R9 valid low after abort", 32'(rd_valid), 0);
    chk("R9 request length", 32'(max_run), 32'(TMO));
    chk("R9 req dropped", 32'(txn_req), 0);
    run_cmd(0, 0, 1);
    chk("R9 probe timeout fails", 32'(probe_fail), 1);
    no_ack = 1'b0;
    run_cmd(0, 1, 0);
    chk("R9 err cleared", 32'(timeout_err), 0);
    chk("R9 read after recovery", 32'(rd_valid), 1);

    chk("R8 handshake violations", 32'(viol), 0);
    finish_run();
  end

endmodule